// File: doc/BRIEF.md
# Two-Pass Product-Term Array with Complement Feedback

This block is a programmable AND-OR plane for one-hot-free state decoding. Each product term forms the AND of input literals. A literal is either an input or its inverse, and the choice comes from per-term true and complement connection masks. A configurable OR plane then merges chosen product terms into each sum output. The block is purely combinational.

A single complement term watches a selected subset of the product terms. It is high only while none of them is high. The complement value is offered back to every product term as one more literal. A term can then act on the condition "no defined state is active", so illegal or unknown states can be steered to a known state without writing a term for each of them.

A term that feeds the complement gate may not use the complement literal, since that would close a loop. The array therefore evaluates in two fixed passes. The first pass builds the terms from the inputs only. The complement is formed from the selected first-pass terms. The second pass then applies the complement literal to the remaining terms.

Top module: `pta_array`

## Requirements
- R1: Product term t is high exactly when, for every input i, the input is high wherever `lit_true_mask[t*N_IN+i]` is set and low wherever `lit_comp_mask[t*N_IN+i]` is set.
- R2: A product term with both the true and the complement connection made to the same input is forced low, whatever the input values.
- R3: A product term with no connection of any kind evaluates high.
- R4: `cmp_out` is low when any product term t with `cmp_sel[t]` set is high, and high when all such terms are low.
- R5: For a term outside the complement selection, `cmp_true_mask[t]` makes the term require `cmp_out` high, and `cmp_comp_mask[t]` makes it require `cmp_out` low.
- R6: For a term with `cmp_sel[t]` set, `cmp_true_mask[t]` and `cmp_comp_mask[t]` are disregarded. This breaks the feedback loop, and such a term depends on the inputs alone.
- R7: Sum output s is the OR of the product terms t whose bit `or_mask[s*N_PT+t]` is set, and is low when none is set.
- R8: With `cmp_sel` all zero, `cmp_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_lit | input | N_IN | Input literals |
| lit_true_mask | input | N_PT*N_IN | True connections, term t uses bits [t*N_IN +: N_IN] |
| lit_comp_mask | input | N_PT*N_IN | Complement connections, same layout |
| cmp_true_mask | input | N_PT | Term uses the complement signal as a true literal |
| cmp_comp_mask | input | N_PT | Term uses the inverted complement signal |
| cmp_sel | input | N_PT | Terms feeding the complement gate |
| or_mask | input | N_SUM*N_PT | Sum s takes terms from bits [s*N_PT +: N_PT] |
| pterm | output | N_PT | Final product terms |
| cmp_out | output | 1 | Complement signal |
| sum_out | output | N_SUM | Sum outputs |

## Verification
Directed patterns come first, one per feature, each in isolation:
- an all-empty configuration separates the empty-AND and empty-OR conventions;
- single-term masks with inputs toggled separate true connections from complement connections and show inhibition;
- a complement selection with its term alternately high and low shows the NOR behaviour and its feedback to other terms;
- a selected term that also carries complement connections shows that the loop is broken.

Randomly drawn sparse masks that respect the no-loop rule then exercise all three planes together. These masks are compared every cycle against a behavioural model, which shows whether complement selection, second-pass terms and the OR merge stay consistent.

// File: rtl/pta_pkg.sv
package pta_pkg;
  // One literal connection: true requires v high, complement requires v low.
  function automatic logic lit_ok(input logic v, input logic t_con, input logic c_con);
    return (!t_con || v) && (!c_con || !v);
  endfunction

  // OR of the masked bits of a 64-bit-or-less selection, computed by the caller.
  function automatic logic nor_reduce(input logic any_hit);
    return !any_hit;
  endfunction
endpackage

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
  parameter int N_IN = 20,
  parameter int N_PT = 64
) (
  input  logic [N_IN-1:0]      in_lit,
  input  logic [N_PT*N_IN-1:0] lit_true_mask,
  input  logic [N_PT*N_IN-1:0] lit_comp_mask,
  input  logic [N_PT-1:0]      cmp_true_mask,
  input  logic [N_PT-1:0]      cmp_comp_mask,
  input  logic [N_PT-1:0]      cmp_sel,
  input  logic                 cmp_in,
  output logic [N_PT-1:0]      pre_term,
  output logic [N_PT-1:0]      pterm
);
  import pta_pkg::*;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_IN-1:0] tm, cm;
    logic            first_pass;
    logic            fb_ok;
    assign tm = lit_true_mask[t*N_IN +: N_IN];
    assign cm = lit_comp_mask[t*N_IN +: N_IN];

    always_comb begin
      first_pass = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        first_pass = first_pass & lit_ok(in_lit[i], tm[i], cm[i]);
      end
    end

    // Complement literal is ignored for terms that feed the complement gate.
    assign fb_ok = cmp_sel[t] ? 1'b1 : lit_ok(cmp_in, cmp_true_mask[t], cmp_comp_mask[t]);
    assign pre_term[t] = first_pass;
    assign pterm[t]    = first_pass & fb_ok;

    always_comb begin
      if ((tm & cm) != '0) begin
        AST_INHIBIT_LOW: assert (!pterm[t]) else $error("inhibited term high"); // R2
      end
      if (tm == '0 && cm == '0 && !cmp_true_mask[t] && !cmp_comp_mask[t]) begin
        AST_EMPTY_HIGH: assert (pterm[t]) else $error("empty term low"); // R3
      end
    end
  end
endmodule

// File: rtl/pta_complement.sv
module pta_complement #(
  parameter int N_PT = 64
) (
  input  logic [N_PT-1:0] pre_term,
  input  logic [N_PT-1:0] cmp_sel,
  output logic            cmp_out
);
  import pta_pkg::*;
  logic any_hit;
  assign any_hit = |(pre_term & cmp_sel);
  assign cmp_out = nor_reduce(any_hit);

  always_comb begin
    if (cmp_sel == '0) begin
      AST_EMPTY_SEL_HIGH: assert (cmp_out) else $error("empty selection low"); // R8
    end
  end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int N_PT  = 64,
  parameter int N_SUM = 32
) (
  input  logic [N_PT-1:0]       pterm,
  input  logic [N_SUM*N_PT-1:0] or_mask,
  output logic [N_SUM-1:0]      sum_out
);
  for (genvar s = 0; s < N_SUM; s++) begin : g_sum
    logic [N_PT-1:0] sel;
    assign sel        = or_mask[s*N_PT +: N_PT];
    assign sum_out[s] = |(pterm & sel);

    always_comb begin
      if (sel == '0) begin
        AST_EMPTY_SUM_LOW: assert (!sum_out[s]) else $error("empty sum high"); // R7
      end
    end
  end
endmodule

// File: rtl/pta_array.sv
module pta_array #(
  parameter int N_IN  = 20,
  parameter int N_PT  = 64,
  parameter int N_SUM = 32
) (
  input  logic [N_IN-1:0]       in_lit,
  input  logic [N_PT*N_IN-1:0]  lit_true_mask,
  input  logic [N_PT*N_IN-1:0]  lit_comp_mask,
  input  logic [N_PT-1:0]       cmp_true_mask,
  input  logic [N_PT-1:0]       cmp_comp_mask,
  input  logic [N_PT-1:0]       cmp_sel,
  input  logic [N_SUM*N_PT-1:0] or_mask,
  output logic [N_PT-1:0]       pterm,
  output logic                  cmp_out,
  output logic [N_SUM-1:0]      sum_out
);
  logic [N_PT-1:0] pre_term;

  pta_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_lit(in_lit), .lit_true_mask(lit_true_mask), .lit_comp_mask(lit_comp_mask),
    .cmp_true_mask(cmp_true_mask), .cmp_comp_mask(cmp_comp_mask), .cmp_sel(cmp_sel),
    .cmp_in(cmp_out), .pre_term(pre_term), .pterm(pterm)
  );

  pta_complement #(.N_PT(N_PT)) u_cmp (
    .pre_term(pre_term), .cmp_sel(cmp_sel), .cmp_out(cmp_out)
  );

  pta_or_plane #(.N_PT(N_PT), .N_SUM(N_SUM)) u_or (
    .pterm(pterm), .or_mask(or_mask), .sum_out(sum_out)
  );

  always_comb begin
    AST_CMP_VS_TERMS: assert (!(cmp_out && ((pterm & cmp_sel) != '0)))
      else $error("complement high with a selected term high"); // R4
    AST_SEL_NO_FEEDBACK: assert ((pterm & cmp_sel) == (pre_term & cmp_sel))
      else $error("selected term depends on complement"); // R6
  end
endmodule

// File: tb/pta_array_tb_top.sv
module pta_array_tb_top;
  localparam int NI = 20;
  localparam int NP = 64;
  localparam int NS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NI-1:0]    in_lit;
  logic [NP*NI-1:0] lt, lc;
  logic [NP-1:0]    ct, cc, sel;
  logic [NS*NP-1:0] om;
  logic [NP-1:0]    pterm;
  logic             cmp_out;
  logic [NS-1:0]    sum_out;

  pta_array #(.N_IN(NI), .N_PT(NP), .N_SUM(NS)) dut_i (
    .in_lit(in_lit), .lit_true_mask(lt), .lit_comp_mask(lc),
    .cmp_true_mask(ct), .cmp_comp_mask(cc), .cmp_sel(sel), .or_mask(om),
    .pterm(pterm), .cmp_out(cmp_out), .sum_out(sum_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int wd = 0;

  logic [NP-1:0] e_pt;
  logic          e_cmp;
  logic [NS-1:0] e_sum;

  // Behavioural reference: first the input-only terms, then the NOR, then the rest.
  task automatic ref_model();
    bit first [NP];
    bit hit;
    for (int t = 0; t < NP; t++) begin
      first[t] = 1;
      for (int i = 0; i < NI; i++) begin
        if (lt[t*NI+i] && !in_lit[i]) first[t] = 0;
        if (lc[t*NI+i] &&  in_lit[i]) first[t] = 0;
      end
    end
    hit = 0;
    for (int t = 0; t < NP; t++) if (sel[t] && first[t]) hit = 1;
    e_cmp = !hit;
    for (int t = 0; t < NP; t++) begin
      bit v;
      v = first[t];
      if (!sel[t]) begin
        if (ct[t] && !e_cmp) v = 0;
        if (cc[t] &&  e_cmp) v = 0;
      end
      e_pt[t] = v;
    end
    for (int s = 0; s < NS; s++) begin
      bit o;
      o = 0;
      for (int t = 0; t < NP; t++) if (om[s*NP+t] && e_pt[t]) o = 1;
      e_sum[s] = o;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    ref_model();
    check({tag, " pterm"}, 64'(pterm), 64'(e_pt));
    check({tag, " cmp"}, 64'(cmp_out), 64'(e_cmp));
    check({tag, " sum"}, 64'(sum_out), 64'(e_sum));
  endtask

  task automatic clear_cfg();
    in_lit = '0; lt = '0; lc = '0; ct = '0; cc = '0; sel = '0; om = '0;
  endtask

  // Drive on posedge, sample on the following negedge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive();
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Empty configuration: terms high (R3), complement high (R8), sums low (R7).
    drive(); clear_cfg(); step();
    check("R3 empty terms", 64'(pterm), {64{1'b1}});
    check("R8 empty selection", 64'(cmp_out), 64'd1);
    check("R7 empty sums", 64'(sum_out), 64'd0);

    // R1: term 0 = in0 & ~in1.
    drive(); lt[0*NI+0] = 1; lc[0*NI+1] = 1; in_lit = 20'b01; step();
    check("R1 true/comp match", 64'(pterm[0]), 64'd1);
    drive(); in_lit = 20'b11; step();
    check("R1 comp mismatch", 64'(pterm[0]), 64'd0);
    drive(); in_lit = 20'b00; step();
    check("R1 true mismatch", 64'(pterm[0]), 64'd0);

    // R2: term 1 both connections on in2.
    drive(); lt[1*NI+2] = 1; lc[1*NI+2] = 1; in_lit = 20'b100; step();
    check("R2 inhibited in2=1", 64'(pterm[1]), 64'd0);
    drive(); in_lit = 20'b000; step();
    check("R2 inhibited in2=0", 64'(pterm[1]), 64'd0);

    // R4/R5: complement watches term 0; term 2 uses cmp true, term 3 uses cmp inverted.
    drive(); clear_cfg(); lt[0*NI+0] = 1; sel[0] = 1; ct[2] = 1; cc[3] = 1;
    in_lit = 20'b1; step();
    check("R4 selected term high", 64'(cmp_out), 64'd0);
    check("R5 true cmp literal", 64'(pterm[2]), 64'd0);
    check("R5 comp cmp literal", 64'(pterm[3]), 64'd1);
    drive(); in_lit = 20'b0; step();
    check("R4 selected terms low", 64'(cmp_out), 64'd1);
    check("R5 true cmp literal low", 64'(pterm[2]), 64'd1);
    check("R5 comp cmp literal low", 64'(pterm[3]), 64'd0);

    // R6: term 0 selected and also marked with cmp connections; they are disregarded.
    drive(); ct[0] = 1; cc[0] = 1; in_lit = 20'b1; step();
    check("R6 selected term ignores cmp", 64'(pterm[0]), 64'd1);
    check("R6 cmp low", 64'(cmp_out), 64'd0);

    // R7: sum 5 = term 2 | term 3.
    drive(); om[5*NP+2] = 1; om[5*NP+3] = 1; in_lit = 20'b0; step();
    check("R7 sum of terms", 64'(sum_out[5]), 64'd1);
    check("R7 other sums low", 64'(sum_out & ~(32'd1 << 5)), 64'd0);
    check_all("R1 R4 R7 directed model");

    // Random sparse masks obeying the no-loop rule, compared every clock.
    for (int n = 0; n < 3000; n++) begin
      drive();
      clear_cfg();
      in_lit = NI'($urandom);
      for (int t = 0; t < NP; t++) begin
        for (int i = 0; i < NI; i++) begin
          int r;
          r = int'($urandom % 24);
          if (r == 0) lt[t*NI+i] = 1;
          else if (r == 1) lc[t*NI+i] = 1;
          else if (r == 2 && ($urandom % 8) == 0) begin lt[t*NI+i] = 1; lc[t*NI+i] = 1; end
        end
        sel[t] = ($urandom % 4) == 0;
        if (!sel[t]) begin
          ct[t] = ($urandom % 4) == 0;
          cc[t] = ($urandom % 4) == 0;
        end
      end
      for (int k = 0; k < NS*NP; k++) om[k] = ($urandom % 8) == 0;
      step();
      check_all("R4 R5 R7 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule